// File: doc/BRIEF.md
# Narrow-Offset Value Materializer

This unit rebuilds a full 64-bit value from a 64-bit base and a small signed offset. It does not carry-propagate across the whole word. A narrow adder sums the offset with the low field of the base. Three candidate upper fields are prepared in parallel: the base's own upper field, that field plus one, and that field minus one. The narrow adder's carry and the offset's sign then pick one of the three. The longest path is the narrow adder plus a three-way select, not a 64-bit carry chain.

The offset is an 11-bit two's-complement integer, so its range is -1024 to +1023. It is sign-extended only inside the low field. A parameter can place one register stage after the select. The default design uses that stage and has a latency of one clock. A valid flag travels alongside the value with the same latency.

Top module: `offset_materializer`

## Requirements
- R1: `out_value` equals `in_base` plus the sign-extended `in_ofs`, modulo 2^64. `in_ofs` is 11-bit two's complement, with bit 10 as the sign.
- R2: When `in_ofs` is zero, `out_value` equals `in_base` bit for bit.
- R3: Bits 10..0 of `out_value` equal bits 10..0 of `in_base` plus `in_ofs`, modulo 2^11.
- R4: When the offset is non-negative and the unsigned sum of the low 11 base bits and the offset reaches 2^11, bits 63..11 of the result equal the base's bits 63..11 plus one. This wraps from all ones to zero.
- R5: When the offset is negative and that unsigned sum stays below 2^11, bits 63..11 of the result equal the base's bits 63..11 minus one. This wraps from zero to all ones.
- R6: In every other case, bits 63..11 of the result equal the base's bits 63..11 unchanged.
- R7: With the register stage enabled (PIPELINED=1, the default), `out_valid` and `out_value` show the inputs from exactly one clock earlier. The value is captured on every clock, whatever `in_valid` is.
- R8: While `rst_n` is low, `out_valid` and `out_value` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks the current base/offset pair as meaningful |
| in_base | input | 64 | Base value |
| in_ofs | input | 11 | Signed offset, two's complement |
| out_valid | output | 1 | Valid flag, delayed like the value |
| out_value | output | 64 | Materialized base plus offset |

## Verification
The assertions assume that `in_base` and `in_ofs` are known (not X) on every clock after reset, including cycles where `in_valid` is low, because the value path registers on every cycle. The stimulus drives the data inputs with defined values at all times. During idle cycles it keeps driving the last pair, or a fresh random pair. The carry-dependent assertions also assume the offset stays in its 11-bit two's-complement range. The stimulus meets this by construction, since it always drives the offset as 11 bits, and it uses both range ends, -1024 and +1023.

// File: rtl/omat_pkg.sv
package omat_pkg;

    localparam int DEF_DATA_W = 64;
    localparam int DEF_OFS_W  = 11;

    typedef enum logic [1:0] {
        UP_KEEP = 2'd0,
        UP_INC  = 2'd1,
        UP_DEC  = 2'd2
    } up_sel_e;

endpackage

// File: rtl/omat_low_add.sv
module omat_low_add #(
    parameter int W = 11
) (
    input  logic [W-1:0] base_lo,
    input  logic [W-1:0] ofs,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] wide;

    always_comb begin
        wide = {1'b0, base_lo} + {1'b0, ofs};
        sum  = wide[W-1:0];
        cout = wide[W];
    end
endmodule

// File: rtl/omat_upper_prep.sv
module omat_upper_prep #(
    parameter int W = 53
) (
    input  logic [W-1:0] upper,
    output logic [W-1:0] upper_inc,
    output logic [W-1:0] upper_dec
);
    always_comb begin
        upper_inc = upper + W'(1);
        upper_dec = upper - W'(1);
    end
endmodule

// File: rtl/omat_up_select.sv
module omat_up_select
    import omat_pkg::*;
#(
    parameter int W = 53
) (
    input  logic         cout,
    input  logic         ofs_neg,
    input  logic [W-1:0] upper_keep,
    input  logic [W-1:0] upper_inc,
    input  logic [W-1:0] upper_dec,
    output logic [W-1:0] upper_out
);
    up_sel_e sel;

    always_comb begin
        if (!ofs_neg && cout)      sel = UP_INC;
        else if (ofs_neg && !cout) sel = UP_DEC;
        else                       sel = UP_KEEP;

        case (sel)
            UP_INC:  upper_out = upper_inc;
            UP_DEC:  upper_out = upper_dec;
            default: upper_out = upper_keep;
        endcase
    end
endmodule

// File: rtl/offset_materializer.sv
module offset_materializer
    import omat_pkg::*;
#(
    parameter int DATA_W    = DEF_DATA_W,
    parameter int OFS_W     = DEF_OFS_W,
    parameter bit PIPELINED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_base,
    input  logic [OFS_W-1:0]  in_ofs,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_value
);
    localparam int UP_W = DATA_W - OFS_W;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] val;
    } stage_t;

    logic [OFS_W-1:0] lo_sum;
    logic             lo_cout;
    logic [UP_W-1:0]  up_inc, up_dec, up_sel;
    stage_t           st_d, st_q;

    omat_low_add #(.W(OFS_W)) low_i (
        .base_lo (in_base[OFS_W-1:0]),
        .ofs     (in_ofs),
        .sum     (lo_sum),
        .cout    (lo_cout)
    );

    omat_upper_prep #(.W(UP_W)) prep_i (
        .upper     (in_base[DATA_W-1:OFS_W]),
        .upper_inc (up_inc),
        .upper_dec (up_dec)
    );

    omat_up_select #(.W(UP_W)) sel_i (
        .cout       (lo_cout),
        .ofs_neg    (in_ofs[OFS_W-1]),
        .upper_keep (in_base[DATA_W-1:OFS_W]),
        .upper_inc  (up_inc),
        .upper_dec  (up_dec),
        .upper_out  (up_sel)
    );

    always_comb begin
        st_d     = '0;
        st_d.vld = in_valid;
        st_d.val = {up_sel, lo_sum};
    end

    generate
        if (PIPELINED) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end
        end else begin : g_comb
            always_comb st_q = st_d;
        end
    endgenerate

    assign out_valid = st_q.vld;
    assign out_value = st_q.val;
endmodule

// File: rtl/omat_checker.sv
module omat_checker #(
    parameter int DATA_W    = 64,
    parameter int OFS_W     = 11,
    parameter bit PIPELINED = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_base,
    input logic [OFS_W-1:0]  in_ofs,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_value
);
    localparam int UP_W = DATA_W - OFS_W;

    logic [DATA_W-1:0] ref_full;
    logic [OFS_W:0]    ref_lo;
    logic              ofs_neg;

    assign ref_full = in_base + {{UP_W{in_ofs[OFS_W-1]}}, in_ofs};
    assign ref_lo   = {1'b0, in_base[OFS_W-1:0]} + {1'b0, in_ofs};
    assign ofs_neg  = in_ofs[OFS_W-1];

    generate
        if (PIPELINED) begin : g_seq
            assert_full_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> out_value == $past(ref_full));
            assert_zero_ofs_R2: assert property (@(posedge clk) disable iff (!rst_n)
                in_ofs == '0 |=> out_value == $past(in_base));
            assert_low_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> out_value[OFS_W-1:0] == $past(ref_lo[OFS_W-1:0]));
            assert_up_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (!ofs_neg && ref_lo[OFS_W]) |=>
                    out_value[DATA_W-1:OFS_W] == $past(in_base[DATA_W-1:OFS_W]) + UP_W'(1));
            assert_up_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (ofs_neg && !ref_lo[OFS_W]) |=>
                    out_value[DATA_W-1:OFS_W] == $past(in_base[DATA_W-1:OFS_W]) - UP_W'(1));
            assert_up_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (ofs_neg == ref_lo[OFS_W]) |=>
                    out_value[DATA_W-1:OFS_W] == $past(in_base[DATA_W-1:OFS_W]));
            assert_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
        end else begin : g_comb
            always @(posedge clk) begin
                if (rst_n) begin
                    assert_full_sum_R1: assert (out_value == ref_full);
                    assert_low_field_R3: assert (out_value[OFS_W-1:0] == ref_lo[OFS_W-1:0]);
                    assert_valid_R7: assert (out_valid == in_valid);
                end
            end
        end
    endgenerate
endmodule

bind offset_materializer omat_checker #(
    .DATA_W(DATA_W), .OFS_W(OFS_W), .PIPELINED(PIPELINED)
) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_base(in_base),
    .in_ofs(in_ofs), .out_valid(out_valid), .out_value(out_value)
);

// File: tb/offset_materializer_tb_top.sv
module offset_materializer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_base = '0;
    logic [10:0] in_ofs = '0;
    logic        out_valid;
    logic [63:0] out_value;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic        exp_vld;
    logic [63:0] exp_val;
    logic [63:0] prev_base;
    logic [10:0] prev_ofs;
    bit          have_exp = 1'b0;

    always #5 clk = ~clk;

    offset_materializer #(.DATA_W(64), .OFS_W(11), .PIPELINED(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_base(in_base),
        .in_ofs(in_ofs), .out_valid(out_valid), .out_value(out_value)
    );

    function automatic logic [63:0] model(input logic [63:0] b, input logic [10:0] o);
        longint signed so;
        so = longint'($signed(o));
        return b + 64'(so);
    endfunction

    task automatic check_prev();
        logic [52:0] ub, uo;
        if (!have_exp) return;
        n_tests++;
        if (out_valid !== exp_vld) begin
            n_fail++;
            $display("FAIL R7 valid: got %0b exp %0b", out_valid, exp_vld);
        end
        n_tests++;
        if (out_value !== exp_val) begin
            n_fail++;
            $display("FAIL R1 value: got %h exp %h", out_value, exp_val);
        end
        n_tests++;
        if (out_value[10:0] !== exp_val[10:0]) begin
            n_fail++;
            $display("FAIL R3 low: got %h exp %h", out_value[10:0], exp_val[10:0]);
        end
        if (prev_ofs == 11'd0) begin
            n_tests++;
            if (out_value !== prev_base) begin
                n_fail++;
                $display("FAIL R2 zero offset: got %h exp %h", out_value, prev_base);
            end
        end
        ub = prev_base[63:11];
        uo = exp_val[63:11];
        n_tests++;
        if (uo == ub + 53'd1) begin
            if (out_value[63:11] !== uo) begin
                n_fail++;
                $display("FAIL R4 upper inc: got %h exp %h", out_value[63:11], uo);
            end
        end else if (uo == ub - 53'd1) begin
            if (out_value[63:11] !== uo) begin
                n_fail++;
                $display("FAIL R5 upper dec: got %h exp %h", out_value[63:11], uo);
            end
        end else begin
            if (out_value[63:11] !== ub) begin
                n_fail++;
                $display("FAIL R6 upper keep: got %h exp %h", out_value[63:11], ub);
            end
        end
    endtask

    task automatic step(input logic [63:0] b, input logic [10:0] o, input logic v);
        @(negedge clk);
        check_prev();
        in_base   = b;
        in_ofs    = o;
        in_valid  = v;
        prev_base = b;
        prev_ofs  = o;
        exp_vld   = v;
        exp_val   = model(b, o);
        have_exp  = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [63:0] bases [8];
        logic [10:0] ofss  [6];
        bases[0] = 64'h0;
        bases[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        bases[2] = 64'h0000_0000_0000_07FF;
        bases[3] = 64'h0000_0000_0000_0400;
        bases[4] = 64'hFFFF_FFFF_FFFF_F800;
        bases[5] = 64'h8000_0000_0000_0000;
        bases[6] = 64'h7FFF_FFFF_FFFF_FFFF;
        bases[7] = 64'h0000_0000_0000_0800;
        ofss[0] = 11'h000;
        ofss[1] = 11'h400;
        ofss[2] = 11'h3FF;
        ofss[3] = 11'h7FF;
        ofss[4] = 11'h001;
        ofss[5] = 11'h555;

        in_base = 64'hDEAD_BEEF_0123_4567;
        in_ofs  = 11'h123;
        in_valid = 1'b1;
        repeat (3) begin
            @(negedge clk);
            n_tests++;
            if (out_valid !== 1'b0 || out_value !== 64'h0) begin
                n_fail++;
                $display("FAIL R8 reset: got %0b/%h exp 0/0", out_valid, out_value);
            end
        end
        rst_n = 1'b1;

        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 6; j++)
                step(bases[i], ofss[j], 1'b1);

        for (int k = 0; k < 3000; k++) begin
            logic [63:0] rb;
            logic [10:0] ro;
            rb = {$urandom(), $urandom()};
            ro = 11'($urandom());
            if (k % 7 == 0) rb[10:0] = 11'h7FF;
            if (k % 11 == 0) rb[10:0] = 11'h000;
            if (k % 13 == 0) ro = 11'h000;
            step(rb, ro, (k % 5) != 0);
        end

        step(64'h1234, 11'h0, 1'b0);
        step(64'h1234, 11'h0, 1'b0);
        @(negedge clk);
        check_prev();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule